// File: doc/BRIEF.md
# Timer-Paced PCM Sample Queue

This block is one streaming channel of a sampled-audio path. Software or a DMA engine writes 32-bit words into a 16-byte queue. Each word carries four signed 8-bit samples. A timer overflow pulse, chosen elsewhere, removes one sample from the queue at a time. The sample rate is therefore set by the timer and not by the block clock; 32 kHz is a common setting.

The current sample stays on the output until the next timer pulse or a flush. When the timer drains the queue down to half full, the block sends a one-cycle refill request so that a DMA engine can top it up without the processor. A timer pulse that finds the queue empty is flagged. So is a word that does not fit.

Two instances form a stereo pair. Mixing and output filtering are done outside the block.

Top module: `pcm_stream_fifo`

## Requirements
- R1: After reset, `sample_out` is 0, the queue is empty, and `dma_req`, `underflow` and `overflow` are all 0.
- R2: An accepted write stores four samples. They leave the queue in this order: bits [7:0] first, then [15:8], then [23:16], then [31:24].
- R3: The queue holds 16 samples (four words), and samples leave in the order they were written.
- R4: A write made while fewer than 4 bytes are free is discarded and does not change the queue contents. `overflow` is then high for exactly the one cycle after that write's clock edge.
- R5: `sample_out` changes only at the edge where `tick` or `flush` is sampled high. It holds its value between such edges.
- R6: A `tick` while the queue is empty leaves `sample_out` unchanged. `underflow` is then high for exactly the one cycle after that edge.
- R7: `dma_req` is high for exactly one cycle, after the edge where a pop takes the fill level from 9 to 8 bytes. It stays low when a write accepted at the same edge keeps the level above 8.
- R8: `flush` empties the queue and sets `sample_out` to 0 at the next edge. A `wr_en` or `tick` in the same cycle is ignored and raises no flag.
- R9: A write and a tick in the same cycle both take effect. Free space is judged on the level before the pop: a write at level 12 is accepted, and a write at level 16 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one 32-bit word |
| wr_data | input | 32 | Four packed signed samples |
| flush | input | 1 | Empties the queue and zeroes the output |
| tick | input | 1 | Timer overflow pulse that pops one sample |
| sample_out | output | 8 | Current signed sample |
| dma_req | output | 1 | One-cycle refill request |
| underflow | output | 1 | One-cycle pulse after a tick on an empty queue |
| overflow | output | 1 | One-cycle pulse after a discarded write |

## Verification
Every result of this block comes from a register. The new sample, the underflow, overflow and refill pulses, and the cleared state after a flush are all due one cycle after the rising edge that captured the `tick`, `wr_en` or `flush`. The bench drives inputs on the falling edge. A monitor records each cycle's inputs at the rising edge and updates a queue-based model there. It then compares all four outputs with that model at the following falling edge, so every output is checked in the cycle it is due. Pulse widths are covered too, because the flags are also compared in every idle cycle.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

  // True when a whole word of wb bytes still fits at the given fill level.
  function automatic logic word_fits(input int level, input int depth, input int wb);
    return (level + wb) <= depth;
  endfunction

  // True when a level move goes from above the mark to at or below it.
  function automatic logic falls_to_mark(input int lvl_now, input int lvl_nxt, input int mark);
    return (lvl_now > mark) && (lvl_nxt <= mark);
  endfunction

endpackage

// File: rtl/pcm_byte_ring.sv
module pcm_byte_ring #(
  parameter int DEPTH      = 16,
  parameter int WORD_BYTES = 4,
  localparam int PW        = $clog2(DEPTH),
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic [8*WORD_BYTES-1:0] push_word,
  input  logic                    pop,
  output logic [7:0]              head_byte,
  output logic [LW-1:0]           level,
  output logic [LW-1:0]           level_nxt
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign head_byte = mem[rd_ptr];

  always_comb begin
    if (clear) level_nxt = '0;
    else       level_nxt = level + (push ? LW'(WORD_BYTES) : '0) - (pop ? LW'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(WORD_BYTES);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      level <= level_nxt;
    end
  end

  // Lowest byte lands at wr_ptr, so it is also the first byte read out.
  always_ff @(posedge clk) begin
    if (push && !clear) begin
      for (int i = 0; i < WORD_BYTES; i++)
        mem[wr_ptr + PW'(i)] <= push_word[8*i +: 8];
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clear) |=> (level == $past(level) - LW'(1)));

endmodule

// File: rtl/pcm_refill_req.sv
module pcm_refill_req #(
  parameter int DEPTH = 16,
  parameter int MARK  = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [LW-1:0] level_now,
  input  logic [LW-1:0] level_nxt,
  output logic          req
);

  import pcm_fifo_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= !clear && falls_to_mark(int'(level_now), int'(level_nxt), MARK);
  end

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

endmodule

// File: rtl/pcm_stream_fifo.sv
module pcm_stream_fifo #(
  parameter int DEPTH      = 16,
  parameter int WORD_BYTES = 4,
  parameter int REQ_MARK   = 8,
  localparam int WW        = 8 * WORD_BYTES,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WW-1:0]     wr_data,
  input  logic              flush,
  input  logic              tick,
  output logic signed [7:0] sample_out,
  output logic              dma_req,
  output logic              underflow,
  output logic              overflow
);

  import pcm_fifo_pkg::*;

  // Named internal events, brought out for the assertions
  logic          room;
  logic          accept_w;
  logic          drop_w;
  logic          pop_w;
  logic          starve_w;
  logic [7:0]    head_byte;
  logic [LW-1:0] level, level_nxt;

  assign room     = word_fits(int'(level), DEPTH, WORD_BYTES);
  assign accept_w = wr_en && !flush && room;
  assign drop_w   = wr_en && !flush && !room;
  assign pop_w    = tick && !flush && (level != '0);
  assign starve_w = tick && !flush && (level == '0);

  pcm_byte_ring #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push      (accept_w),
    .push_word (wr_data),
    .pop       (pop_w),
    .head_byte (head_byte),
    .level     (level),
    .level_nxt (level_nxt)
  );

  pcm_refill_req #(.DEPTH(DEPTH), .MARK(REQ_MARK)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .level_now (level),
    .level_nxt (level_nxt),
    .req       (dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_out <= '0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      underflow <= starve_w;
      overflow  <= drop_w;
      if (flush)      sample_out <= '0;
      else if (pop_w) sample_out <= $signed(head_byte);
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flush) |=> $stable(sample_out));

  p_starve_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    starve_w |=> (underflow && $stable(sample_out)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> (overflow && level == $past(level) - ($past(pop_w) ? LW'(1) : LW'(0))));

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sample_out == 0 && level == '0 && !underflow && !overflow && !dma_req));

  p_space_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && level <= LW'(DEPTH - WORD_BYTES)) |=> !overflow);

endmodule

// File: tb/pcm_stream_fifo_test.sv
module pcm_stream_fifo_test;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic              flush = 1'b0;
  logic              tick = 1'b0;
  logic signed [7:0] sample_out;
  logic              dma_req, underflow, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pcm_stream_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .tick(tick), .sample_out(sample_out),
    .dma_req(dma_req), .underflow(underflow), .overflow(overflow)
  );

  // Scoreboard state
  logic [7:0] exp_q[$];
  logic [7:0] exp_sample = '0;
  bit exp_udf = 0, exp_ovf = 0, exp_req = 0;
  bit pending = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor, part one: update the model from the inputs captured at the edge
  always @(posedge clk) begin
    if (rst_n && !done) begin
      int lvl;
      bit acc, popd;
      lvl = exp_q.size();
      acc = 0; popd = 0;
      exp_udf = 0; exp_ovf = 0; exp_req = 0;
      if (flush) begin
        exp_q.delete();
        exp_sample = '0;
      end else begin
        if (tick) begin
          if (lvl > 0) begin exp_sample = exp_q.pop_front(); popd = 1; end
          else exp_udf = 1;
        end
        if (wr_en) begin
          if (lvl <= 12) begin
            acc = 1;
            for (int b = 0; b < 4; b++) exp_q.push_back(wr_data[8*b +: 8]);
          end else exp_ovf = 1;
        end
        exp_req = (lvl > 8) && ((lvl + (acc ? 4 : 0) - (popd ? 1 : 0)) <= 8);
      end
      pending = 1;
    end
  end

  // Monitor, part two: compare the registered outputs at the next falling edge
  always @(negedge clk) begin
    if (pending && !done) begin
      pending = 0;
      chk(cur_req, "sample_out", int'(sample_out), int'($signed(exp_sample)));
      chk("R6", "underflow", int'(underflow), int'(exp_udf));
      chk("R4", "overflow",  int'(overflow),  int'(exp_ovf));
      chk("R7", "dma_req",   int'(dma_req),   int'(exp_req));
    end
  end

  // Driver: inputs are set on a falling edge and held for one cycle
  task automatic step(input bit we, input logic [31:0] d, input bit t, input bit f);
    wr_en = we; wr_data = d; tick = t; flush = f;
    @(negedge clk);
    wr_en = 0; tick = 0; flush = 0;
  endtask

  task automatic put(input logic [31:0] d); step(1, d, 0, 0); endtask
  task automatic pop1();                    step(0, '0, 1, 0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "reset sample_out", int'(sample_out), 0);
    chk("R1", "reset dma_req", int'(dma_req), 0);
    chk("R1", "reset flags", int'(underflow | overflow), 0);
    idle(2);

    cur_req = "R6"; pop1(); idle(1);             // empty tick

    cur_req = "R2"; put(32'h80_7F_02_FE);         // order FE,02,7F,80
    repeat (4) pop1();
    cur_req = "R6"; pop1(); idle(1);             // hold -128 on underflow

    cur_req = "R3";
    put(32'h04_03_02_01); put(32'h08_07_06_05);
    put(32'h0C_0B_0A_09); put(32'h10_0F_0E_0D);
    cur_req = "R4"; put(32'hDEAD_BEEF);          // full: discarded
    cur_req = "R3";
    repeat (3) pop1();                           // level 13
    cur_req = "R4"; put(32'h5555_5555);          // 3 free: discarded
    cur_req = "R7"; repeat (5) pop1();           // 9 -> 8 raises request
    cur_req = "R5"; pop1(); idle(4); pop1(); idle(3);
    cur_req = "R3"; repeat (6) pop1();           // drains to empty
    cur_req = "R6"; pop1();

    cur_req = "R8";
    put(32'h7F7F_7F7F); pop1();
    step(1, 32'h1111_1111, 1, 1);                // flush wins over write and tick
    cur_req = "R6"; pop1(); idle(1);             // proves queue empty

    cur_req = "R9";
    put(32'hA3_A2_A1_A0); put(32'hB3_B2_B1_B0); put(32'hC3_C2_C1_C0);
    step(1, 32'hD3_D2_D1_D0, 1, 0);              // level 12: accepted, pops A0
    pop1();                                       // level 14
    put(32'hE3_E2_E1_E0);                         // 2 free: discarded
    cur_req = "R7"; step(1, 32'hF3_F2_F1_F0, 1, 0); // 14 dropped; no request
    cur_req = "R9";
    for (int i = 0; i < 14; i++) pop1();
    idle(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule